// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a small table of memory dependency groups for an out-of-order load/store path. A group collects memory operations that do not depend on each other. Each group tracks how many predecessor groups it has and how far those predecessors have got: not started, executing or executed. It also tracks how many member operations it holds and how many of them are executing or have executed. Groups are linked by successor edges of two kinds. An order edge is released as soon as the source group has issued all of its members. A data edge marks the successor's predecessor as executing when the source has fully issued, and as executed only when the source has fully completed.

A scheduler drives one command per clock on a single command port: allocate a group, add a member, link two groups, report a member issued, or report a member executed. Commands name groups by token. Token 0 is never handed out. The block returns per-group status flags, and for each group a critical-predecessor cycle estimate that the scheduler can use to rank waiting groups. The command port has no back-pressure: a command presented with `cmd_valid` high is consumed on that clock edge. A command that would break the group invariants is dropped and raises a sticky error flag.

Top module: `mdg_tracker`

## Requirements
- R1: After reset no group is live, every status flag and critical count is 0, `next_token` is 1 and `err_flag` is 0.
- R2: An allocate command (op 1) makes the group with token `next_token` live, with all counters and successor edges cleared, and `next_token` then advances by one. Tokens run from 1 to GROUPS, and a live group stays live until reset. An allocate with all GROUPS tokens used is rejected.
- R3: A live group is waiting when its predecessor count exceeds executing plus executed predecessors. It is pending when at least one predecessor is executing and executing plus executed predecessors equal the predecessor count. It is ready when executed predecessors equal the predecessor count.
- R4: A live group is executing when its executing-member count is nonzero and equals members minus executed members. It is executed when executed members equal members, so an empty group counts as executed.
- R5: An add-member command (op 2, `cmd_tok`) raises the member count by one. It is rejected if the group is not live, already has successors, or its member count is at its maximum.
- R6: A link command (op 3, source `cmd_tok`, successor `cmd_dst`, `cmd_data`=1 for a data edge) is ignored without error when it is an order edge from a source that is executing. Otherwise it raises the successor's predecessor count by one, and also its executing-predecessor count when the source is executing. It is rejected for a non-live group, a self link, an already-linked pair, a fully executed source, or a predecessor count at its maximum.
- R7: When an issue makes its group executing, each order successor moves one predecessor straight from not started to executed.
- R8: When an issue makes its group executing, each data successor gains one executing predecessor. When the group's last member executes, each data successor moves that predecessor from executing to executed.
- R9: A group's critical count becomes the larger of its current value and the source's largest issued member cycle count (`cmd_cyc` of its issue commands). This happens when a data edge notifies it at issue time, or when it is linked as a data successor to an executing source. On every clock where the group is waiting and the count is nonzero, the count drops by one before any such update.
- R10: An issue command (op 4) is rejected unless the group is live and ready, not already executing, and has an unissued member. An execute command (op 5) is rejected unless the group is live and ready and has an executing member.
- R11: Any rejected command, or an op code of 6 or 7, sets `err_flag`, which stays set until reset. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this clock |
| cmd_op | input | 3 | 0 none, 1 allocate, 2 add member, 3 link, 4 issue, 5 execute |
| cmd_tok | input | TOK_W | Group token the command acts on (source for link) |
| cmd_dst | input | TOK_W | Successor token for link |
| cmd_data | input | 1 | Link is a data edge (1) or an order edge (0) |
| cmd_cyc | input | CYC_W | Remaining cycles of the member reported by an issue |
| next_token | output | TOK_W | Token the next allocate will return |
| grp_live | output | GROUPS | Bit g: token g+1 allocated |
| grp_waiting | output | GROUPS | Bit g: group waiting |
| grp_pending | output | GROUPS | Bit g: group pending |
| grp_ready | output | GROUPS | Bit g: group ready |
| grp_executing | output | GROUPS | Bit g: group executing |
| grp_executed | output | GROUPS | Bit g: group executed |
| grp_crit | output | GROUPS*CYC_W | Critical count of token g+1 in bits [g*CYC_W +: CYC_W] |
| err_flag | output | 1 | Sticky invariant-violation flag |

## Verification
Some properties are checked on every cycle: a live group never leaves the table, and waiting, pending and ready are mutually exclusive. A ready group stays ready unless it gains a predecessor, and an executed group stays executed unless it gains a member. A critical count only rises on a link or issue command, the error flag never clears, and an issue to a group that is not ready raises it. The exact counter movement behind each status change can only be shown by the bench's scenarios. This includes order edges releasing at full issue, data edges passing through pending to ready, the dropped order link, and the critical count's per-clock decay against its max update.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_MEMBER = 3'd2,
    OP_LINK   = 3'd3,
    OP_ISSUE  = 3'd4,
    OP_DONE   = 3'd5
  } mdg_op_e;

  // Per-slot update strobes produced by the dispatcher for one clock.
  typedef struct packed {
    logic alloc;
    logic add_mem;
    logic link;
    logic link_data;
    logic pred_add;
    logic pred_start;
    logic pred_skip;
    logic pred_finish;
    logic mem_issue;
    logic mem_done;
    logic crit_en;
  } slot_ev_t;

endpackage

// File: rtl/mdg_token_alloc.sv
module mdg_token_alloc #(
  parameter int GROUPS = 8,
  parameter int TOK_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [TOK_W-1:0] next_tok,
  output logic             full
);
  localparam logic [TOK_W-1:0] LAST = TOK_W'(GROUPS);

  assign full = (next_tok > LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      next_tok <= TOK_W'(1);
    else if (take && !full)
      next_tok <= next_tok + TOK_W'(1);
  end
endmodule

// File: rtl/mdg_slot.sv
module mdg_slot
  import mdg_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int CNT_W  = 4,
  parameter int CYC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ev_t          ev,
  input  logic [GROUPS-1:0] link_mask,
  input  logic [CYC_W-1:0]  crit_val,
  input  logic [CYC_W-1:0]  mem_cyc,
  output logic              live,
  output logic              waiting,
  output logic              pending,
  output logic              ready,
  output logic              executing,
  output logic              executed,
  output logic [CYC_W-1:0]  crit_pred,
  output logic [CYC_W-1:0]  crit_mem,
  output logic [CNT_W-1:0]  n_pred,
  output logic [CNT_W-1:0]  n_mem,
  output logic [CNT_W-1:0]  n_exing,
  output logic [CNT_W-1:0]  n_exed,
  output logic [GROUPS-1:0] succ_order,
  output logic [GROUPS-1:0] succ_data
);
  logic [CNT_W-1:0] p_exing, p_exed;
  logic [CNT_W:0]   p_sum;
  logic [CYC_W-1:0] crit_dec, crit_nxt;

  // Status decode from the counters, masked by the live bit.
  assign p_sum     = {1'b0, p_exing} + {1'b0, p_exed};
  assign waiting   = live && ({1'b0, n_pred} > p_sum);
  assign pending   = live && (p_exing != '0) && (p_sum == {1'b0, n_pred});
  assign ready     = live && (p_exed == n_pred);
  assign executing = live && (n_exing != '0) && (n_exing == (n_mem - n_exed));
  assign executed  = live && (n_exed == n_mem);

  // Decay first, then merge a notified value as a maximum.
  always_comb begin
    crit_dec = (waiting && crit_pred != '0) ? crit_pred - CYC_W'(1) : crit_pred;
    crit_nxt = crit_dec;
    if (ev.crit_en && crit_val > crit_dec)
      crit_nxt = crit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live       <= 1'b0;
      n_pred     <= '0;
      p_exing    <= '0;
      p_exed     <= '0;
      n_mem      <= '0;
      n_exing    <= '0;
      n_exed     <= '0;
      crit_pred  <= '0;
      crit_mem   <= '0;
      succ_order <= '0;
      succ_data  <= '0;
    end else if (ev.alloc) begin
      live       <= 1'b1;
      n_pred     <= '0;
      p_exing    <= '0;
      p_exed     <= '0;
      n_mem      <= '0;
      n_exing    <= '0;
      n_exed     <= '0;
      crit_pred  <= '0;
      crit_mem   <= '0;
      succ_order <= '0;
      succ_data  <= '0;
    end else begin
      n_mem   <= n_mem + CNT_W'(ev.add_mem);
      n_pred  <= n_pred + CNT_W'(ev.pred_add);
      p_exing <= p_exing + CNT_W'(ev.pred_start) - CNT_W'(ev.pred_finish);
      p_exed  <= p_exed + CNT_W'(ev.pred_skip) + CNT_W'(ev.pred_finish);
      n_exing <= n_exing + CNT_W'(ev.mem_issue) - CNT_W'(ev.mem_done);
      n_exed  <= n_exed + CNT_W'(ev.mem_done);
      crit_pred <= crit_nxt;
      if (ev.mem_issue && mem_cyc > crit_mem)
        crit_mem <= mem_cyc;
      if (ev.link && ev.link_data)
        succ_data <= succ_data | link_mask;
      if (ev.link && !ev.link_data)
        succ_order <= succ_order | link_mask;
    end
  end
endmodule

// File: rtl/mdg_dispatch.sv
module mdg_dispatch
  import mdg_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int CNT_W  = 4,
  parameter int CYC_W  = 6,
  parameter int TOK_W  = 4
) (
  input  logic                               cmd_valid,
  input  logic [2:0]                         cmd_op,
  input  logic [TOK_W-1:0]                   cmd_tok,
  input  logic [TOK_W-1:0]                   cmd_dst,
  input  logic                               cmd_data,
  input  logic [CYC_W-1:0]                   cmd_cyc,
  input  logic [TOK_W-1:0]                   next_tok,
  input  logic                               full,
  input  logic [GROUPS-1:0]                  live,
  input  logic [GROUPS-1:0]                  ready,
  input  logic [GROUPS-1:0]                  executing,
  input  logic [GROUPS-1:0]                  executed,
  input  logic [GROUPS-1:0][CNT_W-1:0]       n_pred,
  input  logic [GROUPS-1:0][CNT_W-1:0]       n_mem,
  input  logic [GROUPS-1:0][CNT_W-1:0]       n_exing,
  input  logic [GROUPS-1:0][CNT_W-1:0]       n_exed,
  input  logic [GROUPS-1:0][CYC_W-1:0]       crit_mem,
  input  logic [GROUPS-1:0][GROUPS-1:0]      succ_order,
  input  logic [GROUPS-1:0][GROUPS-1:0]      succ_data,
  output slot_ev_t [GROUPS-1:0]              ev,
  output logic [GROUPS-1:0]                  link_mask,
  output logic [CYC_W-1:0]                   crit_val,
  output logic                               alloc_go,
  output logic                               bad
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  mdg_op_e             op;
  logic                s_hit, d_hit;
  logic [GROUPS-1:0]   s_oh, d_oh, a_oh, s_so, s_sd;
  logic                s_rdy, s_exing, s_exed;
  logic [CNT_W-1:0]    s_nm, s_nx, s_nd, d_np;
  logic [CYC_W-1:0]    s_cm, cm_new;
  logic [CNT_W:0]      s_started;

  assign op = mdg_op_e'(cmd_op);

  // Select the source and destination slot attributes by token.
  always_comb begin
    s_hit = 1'b0; d_hit = 1'b0;
    s_oh = '0; d_oh = '0; a_oh = '0; s_so = '0; s_sd = '0;
    s_rdy = 1'b0; s_exing = 1'b0; s_exed = 1'b0;
    s_nm = '0; s_nx = '0; s_nd = '0; d_np = '0; s_cm = '0;
    for (int g = 0; g < GROUPS; g++) begin
      a_oh[g] = (next_tok == TOK_W'(g + 1));
      if (cmd_tok == TOK_W'(g + 1) && live[g]) begin
        s_hit   = 1'b1;
        s_oh[g] = 1'b1;
        s_rdy   = ready[g];
        s_exing = executing[g];
        s_exed  = executed[g];
        s_nm    = n_mem[g];
        s_nx    = n_exing[g];
        s_nd    = n_exed[g];
        s_cm    = crit_mem[g];
        s_so    = succ_order[g];
        s_sd    = succ_data[g];
      end
      if (cmd_dst == TOK_W'(g + 1) && live[g]) begin
        d_hit   = 1'b1;
        d_oh[g] = 1'b1;
        d_np    = n_pred[g];
      end
    end
  end

  assign s_started = {1'b0, s_nx} + {1'b0, s_nd};
  assign cm_new    = (cmd_cyc > s_cm) ? cmd_cyc : s_cm;

  always_comb begin
    ev        = '0;
    link_mask = '0;
    crit_val  = '0;
    alloc_go  = 1'b0;
    bad       = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_NONE: ;
        OP_ALLOC: begin
          if (full) bad = 1'b1;
          else begin
            alloc_go = 1'b1;
            for (int g = 0; g < GROUPS; g++) ev[g].alloc = a_oh[g];
          end
        end
        OP_MEMBER: begin
          if (!s_hit || (s_so | s_sd) != '0 || s_nm == CNT_MAX) bad = 1'b1;
          else
            for (int g = 0; g < GROUPS; g++) ev[g].add_mem = s_oh[g];
        end
        OP_LINK: begin
          if (!s_hit || !d_hit || cmd_tok == cmd_dst || s_exed ||
              ((s_so | s_sd) & d_oh) != '0 || d_np == CNT_MAX)
            bad = 1'b1;
          else if (cmd_data || !s_exing) begin
            link_mask = d_oh;
            crit_val  = s_cm;
            for (int g = 0; g < GROUPS; g++) begin
              ev[g].link       = s_oh[g];
              ev[g].link_data  = s_oh[g] & cmd_data;
              ev[g].pred_add   = d_oh[g];
              ev[g].pred_start = d_oh[g] & s_exing;
              ev[g].crit_en    = d_oh[g] & s_exing & cmd_data;
            end
          end
        end
        OP_ISSUE: begin
          if (!s_hit || !s_rdy || s_exing || s_started >= {1'b0, s_nm}) bad = 1'b1;
          else begin
            crit_val = cm_new;
            for (int g = 0; g < GROUPS; g++) begin
              ev[g].mem_issue = s_oh[g];
              if (s_started + (CNT_W+1)'(1) == {1'b0, s_nm}) begin
                ev[g].pred_skip  = s_so[g];
                ev[g].pred_start = s_sd[g];
                ev[g].crit_en    = s_sd[g];
              end
            end
          end
        end
        OP_DONE: begin
          if (!s_hit || !s_rdy || s_nx == '0) bad = 1'b1;
          else
            for (int g = 0; g < GROUPS; g++) begin
              ev[g].mem_done = s_oh[g];
              if ({1'b0, s_nd} + (CNT_W+1)'(1) == {1'b0, s_nm})
                ev[g].pred_finish = s_sd[g];
            end
        end
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mdg_tracker.sv
module mdg_tracker
  import mdg_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int CNT_W  = 4,
  parameter int CYC_W  = 6,
  localparam int TOK_W = $clog2(GROUPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [TOK_W-1:0]          cmd_tok,
  input  logic [TOK_W-1:0]          cmd_dst,
  input  logic                      cmd_data,
  input  logic [CYC_W-1:0]          cmd_cyc,
  output logic [TOK_W-1:0]          next_token,
  output logic [GROUPS-1:0]         grp_live,
  output logic [GROUPS-1:0]         grp_waiting,
  output logic [GROUPS-1:0]         grp_pending,
  output logic [GROUPS-1:0]         grp_ready,
  output logic [GROUPS-1:0]         grp_executing,
  output logic [GROUPS-1:0]         grp_executed,
  output logic [GROUPS*CYC_W-1:0]   grp_crit,
  output logic                      err_flag
);
  slot_ev_t [GROUPS-1:0]         ev;
  logic [GROUPS-1:0]             link_mask;
  logic [CYC_W-1:0]              crit_val;
  logic                          alloc_go, bad, full;
  logic [GROUPS-1:0][CNT_W-1:0]  n_pred, n_mem, n_exing, n_exed;
  logic [GROUPS-1:0][CYC_W-1:0]  crit_mem, crit_pred;
  logic [GROUPS-1:0][GROUPS-1:0] succ_order, succ_data;

  mdg_token_alloc #(.GROUPS(GROUPS), .TOK_W(TOK_W)) i_alloc (
    .clk(clk), .rst_n(rst_n), .take(alloc_go), .next_tok(next_token), .full(full)
  );

  mdg_dispatch #(.GROUPS(GROUPS), .CNT_W(CNT_W), .CYC_W(CYC_W), .TOK_W(TOK_W)) i_disp (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_tok(cmd_tok), .cmd_dst(cmd_dst),
    .cmd_data(cmd_data), .cmd_cyc(cmd_cyc), .next_tok(next_token), .full(full),
    .live(grp_live), .ready(grp_ready), .executing(grp_executing),
    .executed(grp_executed), .n_pred(n_pred), .n_mem(n_mem), .n_exing(n_exing),
    .n_exed(n_exed), .crit_mem(crit_mem), .succ_order(succ_order),
    .succ_data(succ_data), .ev(ev), .link_mask(link_mask), .crit_val(crit_val),
    .alloc_go(alloc_go), .bad(bad)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    mdg_slot #(.GROUPS(GROUPS), .CNT_W(CNT_W), .CYC_W(CYC_W)) i_slot (
      .clk(clk), .rst_n(rst_n), .ev(ev[g]), .link_mask(link_mask),
      .crit_val(crit_val), .mem_cyc(cmd_cyc),
      .live(grp_live[g]), .waiting(grp_waiting[g]), .pending(grp_pending[g]),
      .ready(grp_ready[g]), .executing(grp_executing[g]),
      .executed(grp_executed[g]), .crit_pred(crit_pred[g]),
      .crit_mem(crit_mem[g]), .n_pred(n_pred[g]), .n_mem(n_mem[g]),
      .n_exing(n_exing[g]), .n_exed(n_exed[g]),
      .succ_order(succ_order[g]), .succ_data(succ_data[g])
    );
    assign grp_crit[g*CYC_W +: CYC_W] = crit_pred[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else if (bad) err_flag <= 1'b1;
  end
endmodule

// File: rtl/mdg_tracker_chk.sv
module mdg_tracker_chk #(
  parameter int GROUPS = 8,
  parameter int CYC_W  = 6,
  parameter int TOK_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [2:0]              cmd_op,
  input logic [TOK_W-1:0]        cmd_tok,
  input logic [TOK_W-1:0]        cmd_dst,
  input logic [GROUPS-1:0]       grp_live,
  input logic [GROUPS-1:0]       grp_waiting,
  input logic [GROUPS-1:0]       grp_pending,
  input logic [GROUPS-1:0]       grp_ready,
  input logic [GROUPS-1:0]       grp_executed,
  input logic [GROUPS*CYC_W-1:0] grp_crit,
  input logic                    err_flag
);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    a_r2_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
      grp_live[g] |=> grp_live[g]);

    a_r3_state_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grp_waiting[g], grp_pending[g], grp_ready[g]}));

    a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      grp_ready[g] && !(cmd_valid && cmd_op == 3'd3 && cmd_dst == TOK_W'(g + 1))
      |=> grp_ready[g]);

    a_r4_executed_holds: assert property (@(posedge clk) disable iff (!rst_n)
      grp_executed[g] && !(cmd_valid && cmd_op == 3'd2 && cmd_tok == TOK_W'(g + 1))
      |=> grp_executed[g]);

    a_r9_crit_rise: assert property (@(posedge clk) disable iff (!rst_n)
      grp_crit[g*CYC_W +: CYC_W] > $past(grp_crit[g*CYC_W +: CYC_W])
      |-> $past(cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4)));

    a_r10_issue_unready: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd4 && cmd_tok == TOK_W'(g + 1) && !grp_ready[g]
      |=> err_flag);
  end
endmodule

bind mdg_tracker mdg_tracker_chk #(.GROUPS(GROUPS), .CYC_W(CYC_W), .TOK_W(TOK_W)) i_mdg_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_tok(cmd_tok), .cmd_dst(cmd_dst), .grp_live(grp_live),
  .grp_waiting(grp_waiting), .grp_pending(grp_pending), .grp_ready(grp_ready),
  .grp_executed(grp_executed), .grp_crit(grp_crit), .err_flag(err_flag)
);

// File: tb/test_mdg_tracker.sv
`timescale 1ns/1ps
module test_mdg_tracker;
  localparam int G = 8;
  localparam int YW = 6;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_tok = '0, cmd_dst = '0;
  logic cmd_data = 1'b0;
  logic [YW-1:0] cmd_cyc = '0;
  logic [3:0] next_token;
  logic [G-1:0] grp_live, grp_waiting, grp_pending, grp_ready, grp_executing, grp_executed;
  logic [G*YW-1:0] grp_crit;
  logic err_flag;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdg_tracker i_mdg_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tok(cmd_tok), .cmd_dst(cmd_dst), .cmd_data(cmd_data), .cmd_cyc(cmd_cyc),
    .next_token(next_token), .grp_live(grp_live), .grp_waiting(grp_waiting),
    .grp_pending(grp_pending), .grp_ready(grp_ready), .grp_executing(grp_executing),
    .grp_executed(grp_executed), .grp_crit(grp_crit), .err_flag(err_flag)
  );

  // ---------------- behavioural reference ----------------
  int m_live[9], m_np[9], m_xp[9], m_dp[9], m_nm[9], m_nx[9], m_nd[9], m_cp[9], m_cm[9];
  int m_os[9][$];
  int m_ds[9][$];
  int m_next;
  bit m_err;

  function automatic bit ok(int t); return t >= 1 && t <= G && m_live[t] != 0; endfunction
  function automatic bit f_wait(int g); return m_live[g] != 0 && m_np[g] > m_xp[g] + m_dp[g]; endfunction
  function automatic bit f_pend(int g); return m_live[g] != 0 && m_xp[g] > 0 && m_xp[g] + m_dp[g] == m_np[g]; endfunction
  function automatic bit f_rdy(int g); return m_live[g] != 0 && m_dp[g] == m_np[g]; endfunction
  function automatic bit f_exing(int g); return m_live[g] != 0 && m_nx[g] > 0 && m_nx[g] == m_nm[g] - m_nd[g]; endfunction
  function automatic bit f_exed(int g); return m_live[g] != 0 && m_nd[g] == m_nm[g]; endfunction
  function automatic int mx(int a, int b); return a > b ? a : b; endfunction
  function automatic bit linked(int a, int b);
    foreach (m_os[a][i]) if (m_os[a][i] == b) return 1;
    foreach (m_ds[a][i]) if (m_ds[a][i] == b) return 1;
    return 0;
  endfunction

  task automatic clear_grp(int g);
    m_live[g] = 0; m_np[g] = 0; m_xp[g] = 0; m_dp[g] = 0; m_nm[g] = 0;
    m_nx[g] = 0; m_nd[g] = 0; m_cp[g] = 0; m_cm[g] = 0;
    m_os[g].delete(); m_ds[g].delete();
  endtask

  task automatic model_reset();
    for (int g = 0; g <= G; g++) clear_grp(g);
    m_next = 1; m_err = 0;
  endtask

  task automatic model_step(int op, int a, int b, bit d, int c);
    bit bad = 0;
    for (int g = 1; g <= G; g++) if (f_wait(g) && m_cp[g] > 0) m_cp[g]--;
    case (op)
      0: ;
      1: if (m_next > G) bad = 1; else begin clear_grp(m_next); m_live[m_next] = 1; m_next++; end
      2: if (!ok(a) || m_os[a].size() + m_ds[a].size() > 0 || m_nm[a] == CMAX) bad = 1;
         else m_nm[a]++;
      3: if (!ok(a) || !ok(b) || a == b || f_exed(a) || linked(a, b) || m_np[b] == CMAX) bad = 1;
         else if (d || !f_exing(a)) begin
           m_np[b]++;
           if (f_exing(a)) begin m_xp[b]++; if (d) m_cp[b] = mx(m_cp[b], m_cm[a]); end
           if (d) m_ds[a].push_back(b); else m_os[a].push_back(b);
         end
      4: if (!ok(a) || !f_rdy(a) || f_exing(a) || m_nx[a] + m_nd[a] >= m_nm[a]) bad = 1;
         else begin
           m_nx[a]++; m_cm[a] = mx(m_cm[a], c);
           if (f_exing(a)) begin
             foreach (m_os[a][i]) m_dp[m_os[a][i]]++;
             foreach (m_ds[a][i]) begin
               m_xp[m_ds[a][i]]++;
               m_cp[m_ds[a][i]] = mx(m_cp[m_ds[a][i]], m_cm[a]);
             end
           end
         end
      5: if (!ok(a) || !f_rdy(a) || m_nx[a] == 0) bad = 1;
         else begin
           m_nx[a]--; m_nd[a]++;
           if (m_nd[a] == m_nm[a])
             foreach (m_ds[a][i]) begin m_xp[m_ds[a][i]]--; m_dp[m_ds[a][i]]++; end
         end
      default: bad = 1;
    endcase
    if (bad) m_err = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (cmd_valid) model_step(int'(cmd_op), int'(cmd_tok), int'(cmd_dst), cmd_data, int'(cmd_cyc));
    else model_step(0, 0, 0, 0, 0);
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    for (int g = 1; g <= G; g++) begin
      chk($sformatf("R2 live g%0d", g), int'(grp_live[g-1]), m_live[g]);
      chk($sformatf("R3 waiting g%0d", g), int'(grp_waiting[g-1]), int'(f_wait(g)));
      chk($sformatf("R3 pending g%0d", g), int'(grp_pending[g-1]), int'(f_pend(g)));
      chk($sformatf("R3 ready g%0d", g), int'(grp_ready[g-1]), int'(f_rdy(g)));
      chk($sformatf("R4 executing g%0d", g), int'(grp_executing[g-1]), int'(f_exing(g)));
      chk($sformatf("R4 executed g%0d", g), int'(grp_executed[g-1]), int'(f_exed(g)));
      chk($sformatf("R9 crit g%0d", g), int'(grp_crit[(g-1)*YW +: YW]), m_cp[g]);
    end
    chk("R2 next_token", int'(next_token), m_next);
    chk("R11 err_flag", int'(err_flag), int'(m_err));
  endtask

  always @(negedge clk) if (rst_n && !done) compare();

  function automatic int crit_of(int t); return int'(grp_crit[(t-1)*YW +: YW]); endfunction

  // ---------------- stimulus ----------------
  task automatic send(int op, int a, int b, bit d, int c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_tok = 4'(a); cmd_dst = 4'(b);
    cmd_data = d; cmd_cyc = YW'(c);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 live", int'(grp_live), 0);
    chk("R1 flags", int'(grp_waiting | grp_pending | grp_ready | grp_executing | grp_executed), 0);
    chk("R1 crit", int'(grp_crit != '0), 0);
    chk("R1 next_token", int'(next_token), 1);
    chk("R1 err", int'(err_flag), 0);

    repeat (5) send(1, 0, 0, 0, 0);
    idle();
    chk("R2 five allocated", int'(grp_live), 5'h1f);
    chk("R2 next_token", int'(next_token), 6);
    chk("R4 empty group executed", int'(grp_executed), 5'h1f);

    send(2, 1, 0, 0, 0); send(2, 1, 0, 0, 0); send(2, 2, 0, 0, 0);
    send(3, 1, 2, 0, 0); send(3, 1, 3, 1, 0); send(3, 1, 5, 1, 0); send(3, 2, 5, 0, 0);
    idle();
    chk("R3 g2 waiting", int'(grp_waiting[1]), 1);
    chk("R3 g3 waiting", int'(grp_waiting[2]), 1);
    chk("R3 g5 waiting", int'(grp_waiting[4]), 1);

    send(4, 1, 0, 0, 5);
    send(4, 1, 0, 0, 9);
    idle();
    chk("R4 g1 executing", int'(grp_executing[0]), 1);
    chk("R7 g2 ready after order release", int'(grp_ready[1]), 1);
    chk("R8 g3 pending", int'(grp_pending[2]), 1);
    chk("R9 g3 crit", crit_of(3), 9);
    chk("R9 g5 crit", crit_of(5), 9);
    idle();
    chk("R9 g5 crit decays while waiting", crit_of(5), 8);
    chk("R9 g3 crit holds while pending", crit_of(3), 9);

    send(3, 1, 4, 0, 0);
    idle();
    chk("R6 ignored order link keeps g4 ready", int'(grp_ready[3]), 1);
    chk("R6 ignored order link no error", int'(err_flag), 0);

    send(5, 1, 0, 0, 0);
    idle();
    chk("R8 g3 still pending", int'(grp_pending[2]), 1);
    send(5, 1, 0, 0, 0);
    idle();
    chk("R8 g3 ready after completion", int'(grp_ready[2]), 1);
    chk("R4 g1 executed", int'(grp_executed[0]), 1);

    send(2, 1, 0, 0, 0);
    idle();
    chk("R5 member rejected when successors exist", int'(grp_executed[0]), 1);
    chk("R11 err set", int'(err_flag), 1);

    send(4, 4, 0, 0, 3);
    send(4, 5, 0, 0, 3);
    idle();
    chk("R10 empty group not executing", int'(grp_executing[3]), 0);
    chk("R10 waiting group not executing", int'(grp_executing[4]), 0);
    idle();
    chk("R11 err stays", int'(err_flag), 1);

    for (int r = 0; r < 8; r++) begin
      do_reset();
      for (int k = 0; k < 600; k++) begin
        int w = $urandom_range(0, 99);
        int op = w < 12 ? 1 : w < 30 ? 2 : w < 50 ? 3 : w < 75 ? 4 : w < 95 ? 5 : (w < 97 ? 0 : $urandom_range(6, 7));
        if (r < 4 && op >= 6) op = 0;
        send(op, $urandom_range(0, G + 1), $urandom_range(0, G + 1), 1'($urandom_range(0, 1)),
             $urandom_range(0, (1 << YW) - 1));
      end
      idle();
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule